// File: doc/BRIEF.md
# Tone-Bus Receive Buffer with Silence Timer

This block sits behind the demodulator of a slow single-wire tone signalling bus. Each received byte arrives with the parity bit sent alongside it. The block computes a parity-error flag for the byte and stores all three in an eight-entry first-in first-out buffer. A host drains the buffer through a single fixed read location that has no address increment. For that reason each stored entry is read in two steps. The first read returns the data byte. The second read returns the parity information and then releases the entry. The block also reports how many entries are buffered, and it raises a sticky overflow flag when a byte has to be thrown away.

A second function measures bus silence. A five-bit counter advances on each coarse tick, which is nominally 16 ms and arrives as a one-cycle enable pulse. Every received bit clears the counter to zero, and the counter saturates at its top value. When eleven ticks of silence have passed, the block sets a sticky end-of-message interrupt. A clear strobe from the host removes both sticky flags.

Top module: `tone_rx_fifo`

## Requirements
- R1: The second read of an entry returns `{6'b0, perr, par}`: the stored parity bit in bit 0, the parity-error bit in bit 1 and zeros in bits 7..2. `perr` is the inverse of the XOR of the 8 data bits and the parity bit, so `perr` is 0 when the 9 bits have odd parity.
- R2: While the buffer is not empty and no half-read is pending, `rd_data` shows the data byte of the oldest entry.
- R3: Entries are returned strictly in the order their bytes arrived.
- R4: A read strobe (`rd_en` high for one cycle) while `rd_data` shows a data byte moves only to the parity half of the same entry. The read strobe that follows removes the entry, so `count` drops only after the second read.
- R5: `count` equals the number of stored entries, from 0 to 8. Each accepted byte raises it by one on the cycle after `byte_valid`.
- R6: A byte that arrives while 8 entries are stored is dropped and the stored entries stay unchanged. This holds even if a read happens in the same cycle. The drop sets `ovf_flag`, which stays set until an `irq_clr` strobe.
- R7: `bit_valid` clears `silence` to 0 on the next cycle. It takes priority over a tick in the same cycle.
- R8: `eom_irq` is set on the tick that takes `silence` from 10 to 11. It stays set until `irq_clr` and is not set again within the same silence interval. A set in the same cycle as a clear wins over the clear.
- R9: `silence` counts ticks and holds at 31 once it gets there.
- R10: When the buffer is empty, `rd_data` is 0 and a read strobe has no effect on the pointers or the read phase.
- R11: After reset, `count`, `silence`, `rd_data`, `eom_irq` and `ovf_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_valid | input | 1 | One-cycle pulse for each bit received on the bus |
| byte_valid | input | 1 | One-cycle pulse when a full byte is ready |
| byte_data | input | 8 | Received data byte |
| byte_par | input | 1 | Received parity bit |
| tick | input | 1 | Coarse silence tick enable, one cycle wide |
| rd_en | input | 1 | Read strobe of the fixed read location |
| irq_clr | input | 1 | Clears `eom_irq` and `ovf_flag` |
| rd_data | output | 8 | Read value: data byte or parity word |
| count | output | 4 | Number of buffered entries |
| silence | output | 5 | Ticks since the last received bit |
| eom_irq | output | 1 | Sticky end-of-message interrupt |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Some properties are checked by assertions on every cycle:
- the entry count never goes past the depth;
- a byte pushed into a full buffer leaves the count unchanged;
- an empty buffer reads as zero;
- a received bit always clears the silence counter, and the counter holds at its saturation value;
- the interrupt only rises when the counter shows eleven.

Other behaviour can only be shown by the directed scenarios in the bench:
- the parity-word encoding for both good and bad parity;
- the arrival order across a buffer that has wrapped around;
- the two-read release of each entry;
- the absence of any effect from a read of an empty buffer;
- the one-shot nature of the interrupt after it has been cleared.

// File: rtl/tone_rx_pkg.sv
// Package tone_rx_pkg
// Purpose : types and constants shared by the tone-bus receive buffer.
// Assumes : the bus carries 8-bit bytes with one parity bit each.
package tone_rx_pkg;
    localparam int unsigned DATA_W = 8;

    // One buffered entry: data byte, received parity, computed error flag.
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par;
        logic              perr;
    } rx_entry_t;
endpackage

// File: rtl/rx_parity_check.sv
// Module rx_parity_check
// Purpose : builds a buffer entry from a received byte and its parity bit.
//           The error flag is 0 when the nine bits have odd parity.
// Assumes : purely combinational; the caller decides when to store the entry.
module rx_parity_check
    import tone_rx_pkg::*;
(
    input  logic [DATA_W-1:0] data_in,
    input  logic              par_in,
    output rx_entry_t         entry_out
);
    // Assemble the entry and evaluate odd parity over all nine bits.
    always_comb begin
        entry_out.data = data_in;
        entry_out.par  = par_in;
        entry_out.perr = ~(^{data_in, par_in});
    end
endmodule

// File: rtl/rx_entry_fifo.sv
// Module rx_entry_fifo
// Purpose : circular buffer of received entries, drained through one read
//           location in two steps per entry (data byte, then parity word).
// Assumes : a push into a full buffer is dropped even if a pop happens in
//           the same cycle; reads of an empty buffer are ignored.
module rx_entry_fifo
    import tone_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  rx_entry_t         push_entry,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic              ovf_hit
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH-1);

    rx_entry_t         slot_q [DEPTH];
    logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]     cnt_q;
    logic              phase_q;      // 0: data half next, 1: parity half next
    logic              accept, do_rd, pop;
    rx_entry_t         head;

    // Decode the push and read strobes against the fill level.
    always_comb begin
        accept  = push && (cnt_q != FULL_CNT);
        ovf_hit = push && (cnt_q == FULL_CNT);
        do_rd   = rd_en && (cnt_q != '0);
        pop     = do_rd && phase_q;
    end

    // One storage register per slot, written when the write pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[i] <= '0;
            else if (accept && (wr_ptr_q == AW'(i)))
                slot_q[i] <= push_entry;
        end
    end

    // Advance the write pointer on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_ptr_q <= '0;
        else if (accept)
            wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
    end

    // Advance the read pointer when the second half of an entry is read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_ptr_q <= '0;
        else if (pop)
            rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
    end

    // Toggle the read phase on each valid read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= 1'b0;
        else if (do_rd)
            phase_q <= ~phase_q;
    end

    // Track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (accept && !pop)
            cnt_q <= cnt_q + 1'b1;
        else if (pop && !accept)
            cnt_q <= cnt_q - 1'b1;
    end

    // Select the read value for the current phase.
    always_comb begin
        head = slot_q[rd_ptr_q];
        if (cnt_q == '0)
            rd_data = '0;
        else if (phase_q)
            rd_data = {{(DATA_W-2){1'b0}}, head.perr, head.par};
        else
            rd_data = head.data;
    end

    assign count = cnt_q;

    AST_CNT_WITHIN_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT); // R5
    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (push && cnt_q == FULL_CNT && !pop) |=> (cnt_q == FULL_CNT)); // R6
    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |-> (rd_data == '0)); // R10
    AST_EMPTY_READ_NO_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !push) |=> (cnt_q == '0 && !phase_q)); // R10
endmodule

// File: rtl/rx_silence_timer.sv
// Module rx_silence_timer
// Purpose : counts coarse ticks since the last received bit, saturating,
//           and raises a sticky interrupt once per silence interval.
// Assumes : tick is a one-cycle enable; a bit in the same cycle wins.
module rx_silence_timer #(
    parameter int unsigned SIL_W   = 5,
    parameter int unsigned EOM_CNT = 11
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_seen,
    input  logic             tick,
    input  logic             irq_clr,
    output logic [SIL_W-1:0] silence,
    output logic             eom_irq
);
    localparam logic [SIL_W-1:0] SAT_VAL = {SIL_W{1'b1}};
    localparam logic [SIL_W-1:0] PRE_EOM = SIL_W'(EOM_CNT - 1);

    logic [SIL_W-1:0] cnt_q;
    logic             irq_q;
    logic             eom_hit;

    // Detect the tick that reaches the end-of-message count.
    always_comb eom_hit = tick && !bit_seen && (cnt_q == PRE_EOM);

    // Silence counter: cleared by a bit, otherwise saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (bit_seen)
            cnt_q <= '0;
        else if (tick && (cnt_q != SAT_VAL))
            cnt_q <= cnt_q + 1'b1;
    end

    // Sticky interrupt: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (eom_hit)
            irq_q <= 1'b1;
        else if (irq_clr)
            irq_q <= 1'b0;
    end

    assign silence = cnt_q;
    assign eom_irq = irq_q;

    AST_BIT_CLEARS_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_seen |=> (cnt_q == '0)); // R7
    AST_SILENCE_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == SAT_VAL && !bit_seen) |=> (cnt_q == SAT_VAL)); // R9
    AST_IRQ_RISES_AT_EOM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> (cnt_q == SIL_W'(EOM_CNT))); // R8
endmodule

// File: rtl/tone_rx_fifo.sv
// Module tone_rx_fifo
// Purpose : top of the tone-bus receive buffer. It ties together the parity
//           check, the entry buffer, the silence timer and the overflow flag.
// Assumes : byte_valid and bit_valid come from an upstream demodulator, and
//           rd_en is one strobe per host read of the fixed location.
module tone_rx_fifo
    import tone_rx_pkg::*;
#(
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned SIL_W   = 5,
    parameter int unsigned EOM_CNT = 11
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bit_valid,
    input  logic                       byte_valid,
    input  logic [DATA_W-1:0]          byte_data,
    input  logic                       byte_par,
    input  logic                       tick,
    input  logic                       rd_en,
    input  logic                       irq_clr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic [SIL_W-1:0]           silence,
    output logic                       eom_irq,
    output logic                       ovf_flag
);
    rx_entry_t new_entry;
    logic      ovf_hit;
    logic      ovf_q;

    rx_parity_check u_par (
        .data_in   (byte_data),
        .par_in    (byte_par),
        .entry_out (new_entry)
    );

    rx_entry_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (byte_valid),
        .push_entry (new_entry),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .count      (count),
        .ovf_hit    (ovf_hit)
    );

    rx_silence_timer #(.SIL_W(SIL_W), .EOM_CNT(EOM_CNT)) u_sil (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_seen (bit_valid),
        .tick     (tick),
        .irq_clr  (irq_clr),
        .silence  (silence),
        .eom_irq  (eom_irq)
    );

    // Sticky overflow flag: set by a dropped byte, cleared by the host strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (ovf_hit)
            ovf_q <= 1'b1;
        else if (irq_clr)
            ovf_q <= 1'b0;
    end

    assign ovf_flag = ovf_q;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !irq_clr) |=> ovf_q); // R6
endmodule

// File: tb/test_tone_rx_fifo.sv
module test_tone_rx_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0, byte_valid = 1'b0, byte_par = 1'b0;
    logic [7:0] byte_data = '0;
    logic       tick = 1'b0, rd_en = 1'b0, irq_clr = 1'b0;
    logic [7:0] rd_data;
    logic [3:0] count;
    logic [4:0] silence;
    logic       eom_irq, ovf_flag;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    tone_rx_fifo i_tone_rx_fifo (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_par(byte_par), .tick(tick), .rd_en(rd_en),
        .irq_clr(irq_clr), .rd_data(rd_data), .count(count), .silence(silence),
        .eom_irq(eom_irq), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] par_word(input logic [7:0] d, input logic p);
        return {~(^{d, p}), p};
    endfunction

    // Inputs are driven just after a falling edge; outputs are sampled at the next falling edge.
    task automatic push_byte(input logic [7:0] d, input logic p);
        byte_data = d; byte_par = p; byte_valid = 1'b1; bit_valid = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0; bit_valid = 1'b0;
    endtask

    task automatic rd_strobe;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_tick;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pulse_clr;
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic read_entry(input logic [7:0] d, input logic p, input int cnt_before);
        chk("R2 data half", rd_data, d);
        rd_strobe();
        chk("R4 count kept after first read", count, cnt_before);
        chk("R1 parity half", rd_data, {6'b0, par_word(d, p)});
        rd_strobe();
        chk("R4 count after second read", count, cnt_before - 1);
    endtask

    task automatic t_reset;
        chk("R11 count", count, 0);
        chk("R11 silence", silence, 0);
        chk("R11 rd_data", rd_data, 0);
        chk("R11 eom_irq", eom_irq, 0);
        chk("R11 ovf_flag", ovf_flag, 0);
    endtask

    task automatic t_parity;
        push_byte(8'hA5, 1'b1);   // 4 ones + 1 = odd -> perr 0
        chk("R5 count after push", count, 1);
        chk("R1 good parity word", {6'b0, par_word(8'hA5, 1'b1)}, 1);
        read_entry(8'hA5, 1'b1, 1);
        push_byte(8'h07, 1'b1);   // 3 + 1 = even -> perr 1
        push_byte(8'h00, 1'b0);   // 0 ones = even -> perr 1
        read_entry(8'h07, 1'b1, 2);
        read_entry(8'h00, 1'b0, 1);
    endtask

    task automatic t_empty_read;
        chk("R10 empty reads zero", rd_data, 0);
        rd_strobe();
        rd_strobe();
        rd_strobe();
        chk("R10 count after empty reads", count, 0);
        push_byte(8'h3C, 1'b0);
        chk("R10 phase unchanged by empty read", rd_data, 8'h3C);
        read_entry(8'h3C, 1'b0, 1);
    endtask

    task automatic t_order_overflow;
        for (int i = 0; i < 8; i++) push_byte(8'(8'h10 + i), 1'(i));
        chk("R5 full count", count, 8);
        chk("R6 no overflow yet", ovf_flag, 0);
        push_byte(8'hEE, 1'b1);
        chk("R6 count after drop", count, 8);
        chk("R6 overflow flag set", ovf_flag, 1);
        for (int i = 0; i < 8; i++) read_entry(8'(8'h10 + i), 1'(i), 8 - i);
        chk("R3 drained", count, 0);
        chk("R6 flag sticky", ovf_flag, 1);
        pulse_clr();
        chk("R6 flag cleared", ovf_flag, 0);
        // wrapped order check
        for (int i = 0; i < 5; i++) push_byte(8'(8'hC0 + i), 1'b0);
        for (int i = 0; i < 5; i++) read_entry(8'(8'hC0 + i), 1'b0, 5 - i);
    endtask

    task automatic t_silence;
        bit_valid = 1'b1; @(negedge clk); bit_valid = 1'b0;
        chk("R7 cleared by bit", silence, 0);
        for (int i = 0; i < 10; i++) pulse_tick();
        chk("R9 count ten", silence, 10);
        chk("R8 no irq at ten", eom_irq, 0);
        pulse_tick();
        chk("R8 silence eleven", silence, 11);
        chk("R8 irq at eleven", eom_irq, 1);
        pulse_tick();
        chk("R8 irq sticky", eom_irq, 1);
        pulse_clr();
        chk("R8 irq cleared", eom_irq, 0);
        for (int i = 0; i < 25; i++) pulse_tick();
        chk("R9 saturated", silence, 31);
        chk("R8 no second irq", eom_irq, 0);
        tick = 1'b1; bit_valid = 1'b1;
        @(negedge clk);
        tick = 1'b0; bit_valid = 1'b0;
        chk("R7 bit wins over tick", silence, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_parity();
        t_empty_read();
        t_order_overflow();
        t_silence();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule